// File: doc/BRIEF.md
# I/O Channel Group Request Scanner

This block decides which I/O channel path is serviced next. Twelve full-duplex 16-bit channels give 24 one-way paths. The paths are split into four groups of six. Every path in a group runs in the same direction: all input or all output. Each path has three control lines. A ready pulse means a word is present on the path. A resume pulse means the far end took a word. A disconnect pulse means the transfer has ended. The block latches each pulse as a pending event on its path and keeps it until that path is granted.

A scan pointer moves to the next group on every clock and wraps after the last group. Each group therefore comes up once every four clocks, whether or not anything is waiting in it. In a group's slot, if any of its paths has a pending event, the block issues one grant. The grant names the group, the channel number inside the group (0 to 5), the direction, and the latched event bits of that path. Granting a path clears its latched events. A path that loses keeps its events for the group's next slot. The word transfer that follows a grant is handled elsewhere.

Top module: `io_chan_scanner`

## Requirements
- R1: While reset is held, and on the first cycle after it, `gnt_vld_o` is 0 and `scan_grp_o` is 0.
- R2: `scan_grp_o` advances by one group on every clock and wraps from 3 back to 0. Each group is therefore shown once every 4 clocks.
- R3: A grant shown in a cycle always carries the group that `scan_grp_o` showed in the cycle before it.
- R4: When several paths of the scanned group are pending, the grant goes to the lowest channel number.
- R5: At most one grant is issued per cycle. No grant is issued when the scanned group has no pending path, and a grant's event bits are never all zero.
- R6: A pending path that loses arbitration stays pending and is granted at a later slot of its group. After all 24 paths are set at once, exactly 24 grants follow.
- R7: `gnt_evt_o` holds the path's latched events: bit 0 is ready, bit 1 is resume, bit 2 is disconnect. The latch is cleared when the path is granted.
- R8: An event that arrives on a path in the same cycle as that path's grant is kept pending. It is granted at the group's next slot, 4 clocks later.
- R9: `gnt_out_o` is 1 for output groups and 0 for input groups. With the default mask, groups 2 and 3 are output and groups 0 and 1 are input.
- R10: Path bit `p` of each control bus belongs to group `p / 6`, channel `p % 6`. A single pulse on bit `p` produces exactly one grant, and that grant carries that group and channel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| rdy_i | input | 24 | Ready (data present) pulse for each path |
| rsm_i | input | 24 | Resume (data received) pulse for each path |
| dsc_i | input | 24 | Disconnect (transfer complete) pulse for each path |
| scan_grp_o | output | 2 | Group the scanner examines this cycle |
| gnt_vld_o | output | 1 | A grant is issued this cycle |
| gnt_grp_o | output | 2 | Group of the granted path |
| gnt_chn_o | output | 3 | Channel of the granted path within its group |
| gnt_out_o | output | 1 | Direction of the granted path (1 = output) |
| gnt_evt_o | output | 3 | Latched events of the granted path {disconnect, resume, ready} |

## Verification
The critical overlap is a path being granted, which clears its latch, in the same cycle that a new event arrives on that path, which sets its latch. The bench provokes this by holding resume high on one path over many scan rounds. Random bursts at 1/2 density make the overlap happen on many other paths as well. A bench-side model, in which a grant clears first and new events are merged after, predicts the event bits and the slot of every re-grant. The bench compares every grant against this model and checks that the re-grant appears exactly one scan round later.

// File: rtl/io_scan_pkg.sv
package io_scan_pkg;
  // Latched control events of one path; bit 0 ready, bit 1 resume, bit 2 disconnect
  typedef struct packed {
    logic dsc;
    logic rsm;
    logic rdy;
  } chan_evt_t;

  localparam int unsigned EVT_W = 3;
endpackage

// File: rtl/io_scan_rst_sync.sv
module io_scan_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_core_n
);
  logic [1:0] sync_d;
  logic [1:0] sync_q;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign rst_core_n = sync_q[1];
endmodule

// File: rtl/io_scan_ptr.sv
module io_scan_ptr #(
  parameter int unsigned N_GRP = 4,
  parameter int unsigned GID_W = 2
) (
  input  logic             clk,
  input  logic             rst_core_n,
  output logic [GID_W-1:0] ptr_o
);
  logic [GID_W-1:0] ptr_d;
  logic [GID_W-1:0] ptr_q;
  logic             at_last;

  always_comb begin
    at_last = (ptr_q == GID_W'(N_GRP - 1));
    if (at_last) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_q + GID_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      ptr_q <= '0;
    end else begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/io_scan_pend.sv
module io_scan_pend
  import io_scan_pkg::*;
#(
  parameter int unsigned N_PATH = 24
) (
  input  logic                   clk,
  input  logic                   rst_core_n,
  input  logic [N_PATH-1:0]      rdy_i,
  input  logic [N_PATH-1:0]      rsm_i,
  input  logic [N_PATH-1:0]      dsc_i,
  input  logic [N_PATH-1:0]      clr_i,
  output chan_evt_t [N_PATH-1:0] pend_o
);
  for (genvar p = 0; p < N_PATH; p++) begin : g_path
    chan_evt_t arr;
    chan_evt_t evt_d;
    chan_evt_t evt_q;
    logic      evt_en;

    assign arr = chan_evt_t'({dsc_i[p], rsm_i[p], rdy_i[p]});

    // clear of a granted path comes first, fresh arrivals are merged after it
    always_comb begin
      evt_en = clr_i[p] | (|arr);
      if (clr_i[p]) begin
        evt_d = arr;
      end else begin
        evt_d = chan_evt_t'(evt_q | arr);
      end
    end

    always_ff @(posedge clk or negedge rst_core_n) begin
      if (!rst_core_n) begin
        evt_q <= '0;
      end else if (evt_en) begin
        evt_q <= evt_d;
      end
    end

    assign pend_o[p] = evt_q;
  end
endmodule

// File: rtl/io_scan_pick.sv
module io_scan_pick
  import io_scan_pkg::*;
#(
  parameter int unsigned N_GRP     = 4,
  parameter int unsigned GRP_PATHS = 6,
  parameter int unsigned GID_W     = 2,
  parameter int unsigned CID_W     = 3,
  localparam int unsigned N_PATH   = N_GRP * GRP_PATHS
) (
  input  logic [N_PATH-1:0]      busy_i,
  input  chan_evt_t [N_PATH-1:0] pend_i,
  input  logic [GID_W-1:0]       sel_i,
  output logic                   hit_o,
  output logic [CID_W-1:0]       chn_o,
  output chan_evt_t              evt_o
);
  logic [N_GRP-1:0]       grp_any;
  logic [N_GRP*CID_W-1:0] grp_low;

  // one fixed-priority encoder per group
  for (genvar g = 0; g < N_GRP; g++) begin : g_grp
    logic             any_l;
    logic [CID_W-1:0] low_l;

    always_comb begin
      any_l = 1'b0;
      low_l = '0;
      for (int c = GRP_PATHS - 1; c >= 0; c--) begin
        if (busy_i[g*GRP_PATHS + c]) begin
          any_l = 1'b1;
          low_l = CID_W'(c);
        end
      end
    end

    assign grp_any[g]                 = any_l;
    assign grp_low[g*CID_W +: CID_W]  = low_l;
  end

  int unsigned sel_idx;
  int unsigned path_idx;

  always_comb begin
    sel_idx  = int'(sel_i);
    hit_o    = 1'b0;
    chn_o    = '0;
    evt_o    = '0;
    path_idx = 0;
    if (sel_idx < N_GRP) begin
      hit_o    = grp_any[sel_idx];
      chn_o    = grp_low[sel_idx*CID_W +: CID_W];
      path_idx = sel_idx * GRP_PATHS + int'(chn_o);
      if (path_idx < N_PATH) begin
        evt_o = pend_i[path_idx];
      end
    end
  end
endmodule

// File: rtl/io_chan_scanner.sv
module io_chan_scanner
  import io_scan_pkg::*;
#(
  parameter int unsigned   N_GRP        = 4,
  parameter int unsigned   GRP_PATHS    = 6,
  parameter logic [N_GRP-1:0] OUT_GRP_MASK = 4'b1100,
  localparam int unsigned  N_PATH       = N_GRP * GRP_PATHS,
  localparam int unsigned  GID_W        = (N_GRP > 1) ? $clog2(N_GRP) : 1,
  localparam int unsigned  CID_W        = (GRP_PATHS > 1) ? $clog2(GRP_PATHS) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PATH-1:0] rdy_i,
  input  logic [N_PATH-1:0] rsm_i,
  input  logic [N_PATH-1:0] dsc_i,
  output logic [GID_W-1:0]  scan_grp_o,
  output logic              gnt_vld_o,
  output logic [GID_W-1:0]  gnt_grp_o,
  output logic [CID_W-1:0]  gnt_chn_o,
  output logic              gnt_out_o,
  output logic [EVT_W-1:0]  gnt_evt_o
);
  logic                   rst_core_n;
  logic [GID_W-1:0]       ptr;
  chan_evt_t [N_PATH-1:0] pend_q;
  logic [N_PATH-1:0]      pend_busy;
  logic [N_PATH-1:0]      clr;
  logic                   hit;
  logic [CID_W-1:0]       pick_chn;
  chan_evt_t              pick_evt;

  io_scan_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_core_n (rst_core_n)
  );

  io_scan_ptr #(
    .N_GRP (N_GRP),
    .GID_W (GID_W)
  ) u_ptr (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .ptr_o      (ptr)
  );

  io_scan_pend #(
    .N_PATH (N_PATH)
  ) u_pend (
    .clk        (clk),
    .rst_core_n (rst_core_n),
    .rdy_i      (rdy_i),
    .rsm_i      (rsm_i),
    .dsc_i      (dsc_i),
    .clr_i      (clr),
    .pend_o     (pend_q)
  );

  for (genvar p = 0; p < N_PATH; p++) begin : g_busy
    assign pend_busy[p] = |pend_q[p];
  end

  io_scan_pick #(
    .N_GRP     (N_GRP),
    .GRP_PATHS (GRP_PATHS),
    .GID_W     (GID_W),
    .CID_W     (CID_W)
  ) u_pick (
    .busy_i (pend_busy),
    .pend_i (pend_q),
    .sel_i  (ptr),
    .hit_o  (hit),
    .chn_o  (pick_chn),
    .evt_o  (pick_evt)
  );

  // one-hot clear of the path being granted
  int unsigned gnt_idx;
  always_comb begin
    clr     = '0;
    gnt_idx = int'(ptr) * GRP_PATHS + int'(pick_chn);
    if (hit && (gnt_idx < N_PATH)) begin
      clr[gnt_idx] = 1'b1;
    end
  end

  // grant register: next state, then storage
  logic             vld_d;
  logic [GID_W-1:0] grp_d;
  logic [CID_W-1:0] chn_d;
  logic             out_d;
  chan_evt_t        evt_d;

  always_comb begin
    vld_d = hit;
    grp_d = ptr;
    chn_d = pick_chn;
    out_d = OUT_GRP_MASK[ptr];
    evt_d = pick_evt;
  end

  logic             vld_q;
  logic [GID_W-1:0] grp_q;
  logic [CID_W-1:0] chn_q;
  logic             out_q;
  chan_evt_t        evt_q;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      vld_q <= 1'b0;
      grp_q <= '0;
      chn_q <= '0;
      out_q <= 1'b0;
      evt_q <= '0;
    end else begin
      vld_q <= vld_d;
      if (hit) begin
        grp_q <= grp_d;
        chn_q <= chn_d;
        out_q <= out_d;
        evt_q <= evt_d;
      end
    end
  end

  assign scan_grp_o = ptr;
  assign gnt_vld_o  = vld_q;
  assign gnt_grp_o  = grp_q;
  assign gnt_chn_o  = chn_q;
  assign gnt_out_o  = out_q;
  assign gnt_evt_o  = evt_q;
endmodule

// File: rtl/io_chan_scanner_chk.sv
module io_chan_scanner_chk #(
  parameter int unsigned      N_GRP        = 4,
  parameter int unsigned      GRP_PATHS    = 6,
  parameter logic [N_GRP-1:0] OUT_GRP_MASK = 4'b1100,
  parameter int unsigned      GID_W        = 2,
  parameter int unsigned      CID_W        = 3,
  localparam int unsigned     N_PATH       = N_GRP * GRP_PATHS
) (
  input logic              clk,
  input logic              rst_core_n,
  input logic [GID_W-1:0]  scan,
  input logic              vld,
  input logic [GID_W-1:0]  grp,
  input logic [CID_W-1:0]  chn,
  input logic              dir,
  input logic [2:0]        evt,
  input logic [N_PATH-1:0] busy
);
  logic              run_q;
  logic [N_PATH-1:0] busy_d;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      run_q  <= 1'b0;
      busy_d <= '0;
    end else begin
      run_q  <= 1'b1;
      busy_d <= busy;
    end
  end

  logic        lower_busy;
  logic        self_busy;
  int unsigned base;

  always_comb begin
    lower_busy = 1'b0;
    self_busy  = 1'b0;
    base       = int'(grp) * GRP_PATHS;
    for (int c = 0; c < GRP_PATHS; c++) begin
      if ((base + c) < N_PATH) begin
        if (c < int'(chn)) lower_busy = lower_busy | busy_d[base + c];
        if (c == int'(chn)) self_busy = busy_d[base + c];
      end
    end
  end

  // R2
  scan_step_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    run_q |-> (scan == (($past(scan) == GID_W'(N_GRP - 1)) ? '0 : $past(scan) + GID_W'(1))));

  // R3
  gnt_grp_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    (run_q && vld) |-> (grp == $past(scan)));

  // R4
  gnt_low_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    vld |-> (self_busy && !lower_busy));

  // R5
  gnt_evt_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    vld |-> (evt != 3'b000));

  // R9
  gnt_dir_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    vld |-> (dir == OUT_GRP_MASK[grp]));
endmodule

bind io_chan_scanner io_chan_scanner_chk #(
  .N_GRP        (N_GRP),
  .GRP_PATHS    (GRP_PATHS),
  .OUT_GRP_MASK (OUT_GRP_MASK),
  .GID_W        (GID_W),
  .CID_W        (CID_W)
) u_chk (
  .clk        (clk),
  .rst_core_n (rst_core_n),
  .scan       (scan_grp_o),
  .vld        (gnt_vld_o),
  .grp        (gnt_grp_o),
  .chn        (gnt_chn_o),
  .dir        (gnt_out_o),
  .evt        (gnt_evt_o),
  .busy       (pend_busy)
);

// File: tb/io_chan_scanner_tb.sv
`timescale 1ns/1ps
module io_chan_scanner_tb;
  localparam int NP = 24;
  localparam int GP = 6;
  localparam logic [3:0] DIR_MASK = 4'b1100;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] rdy, rsm, dsc;
  logic [1:0]    scan_grp;
  logic          gnt_vld;
  logic [1:0]    gnt_grp;
  logic [2:0]    gnt_chn;
  logic          gnt_out;
  logic [2:0]    gnt_evt;

  io_chan_scanner u_dut (
    .clk        (clk),
    .rst_n      (rst_n),
    .rdy_i      (rdy),
    .rsm_i      (rsm),
    .dsc_i      (dsc),
    .scan_grp_o (scan_grp),
    .gnt_vld_o  (gnt_vld),
    .gnt_grp_o  (gnt_grp),
    .gnt_chn_o  (gnt_chn),
    .gnt_out_o  (gnt_out),
    .gnt_evt_o  (gnt_evt)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  // bench model
  logic [2:0] m_pend [NP];
  int         m_ptr;
  bit         e_vld;
  int         e_grp, e_chn, e_evt, e_out;
  int         obs_cnt, obs_last, obs13, exp13;
  logic [31:0] seed = 32'h2468ace1;

  function automatic logic [31:0] nxt(input logic [31:0] s);
    logic [31:0] x;
    x = s;
    x = x ^ (x << 13);
    x = x ^ (x >> 17);
    x = x ^ (x << 5);
    return x;
  endfunction

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step(input logic [NP-1:0] r, input logic [NP-1:0] s, input logic [NP-1:0] d);
    @(negedge clk);
    chk(int'(scan_grp) == m_ptr, "R2 scan group", int'(scan_grp), m_ptr);
    chk(gnt_vld == e_vld, "R5 grant valid", int'(gnt_vld), int'(e_vld));
    if (e_vld && gnt_vld) begin
      chk(int'(gnt_grp) == e_grp, "R3 grant group", int'(gnt_grp), e_grp);
      chk(int'(gnt_chn) == e_chn, "R4 grant channel", int'(gnt_chn), e_chn);
      chk(int'(gnt_evt) == e_evt, "R7 grant events", int'(gnt_evt), e_evt);
      chk(int'(gnt_out) == e_out, "R9 grant direction", int'(gnt_out), e_out);
    end
    if (gnt_vld) begin
      obs_cnt++;
      obs_last = int'(gnt_grp) * GP + int'(gnt_chn);
      if (obs_last == 13) obs13++;
    end
    rdy = r;
    rsm = s;
    dsc = d;
    // model of the coming edge: grant from old state, then merge arrivals
    e_vld = 0;
    e_grp = m_ptr;
    e_out = int'(DIR_MASK[m_ptr]);
    for (int c = 0; c < GP; c++) begin
      if (!e_vld && m_pend[m_ptr*GP + c] != 3'b000) begin
        e_vld = 1;
        e_chn = c;
        e_evt = int'(m_pend[m_ptr*GP + c]);
        m_pend[m_ptr*GP + c] = 3'b000;
        if (m_ptr*GP + c == 13) exp13++;
      end
    end
    for (int p = 0; p < NP; p++) m_pend[p] = m_pend[p] | {d[p], s[p], r[p]};
    m_ptr = (m_ptr + 1) % 4;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step('0, '0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++;
      total++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [NP-1:0] v;
    rst_n = 1'b0;
    rdy = '0; rsm = '0; dsc = '0;
    for (int p = 0; p < NP; p++) m_pend[p] = 3'b000;
    m_ptr = 0; e_vld = 0; e_grp = 0; e_chn = 0; e_evt = 0; e_out = 0;
    obs_cnt = 0; obs_last = 0; obs13 = 0; exp13 = 0;
    repeat (3) @(negedge clk);
    // R1 reset state while held
    chk(gnt_vld == 1'b0, "R1 reset valid", int'(gnt_vld), 0);
    chk(scan_grp == 2'd0, "R1 reset scan", int'(scan_grp), 0);
    rst_n = 1'b1;
    repeat (2) @(posedge clk);

    // R1/R5: quiet period, no grants, pointer rotation only
    idle(8);

    // R10 / R7: one pulse per path, each kind in turn
    for (int p = 0; p < NP; p++) begin
      v = '0;
      v[p] = 1'b1;
      obs_cnt = 0;
      case (p % 3)
        0: step(v, '0, '0);
        1: step('0, v, '0);
        default: step('0, '0, v);
      endcase
      idle(5);
      chk(obs_cnt == 1, "R10 single grant count", obs_cnt, 1);
      chk(obs_last == p, "R10 path mapping", obs_last, p);
    end

    // R4 / R6: every path at once drains lowest first, nothing lost
    obs_cnt = 0;
    step('1, '1, '1);
    idle(30);
    chk(obs_cnt == NP, "R6 burst grant count", obs_cnt, NP);

    // R8: resume held on path 13 (group 2, channel 1) across many rounds
    obs13 = 0;
    exp13 = 0;
    v = '0;
    v[13] = 1'b1;
    step(v, '0, '0);
    for (int i = 0; i < 16; i++) step('0, v, '0);
    idle(8);
    chk(obs13 == exp13, "R8 regrant count", obs13, exp13);
    chk(obs13 >= 4, "R8 regrant every round", obs13, 4);

    // sparse random traffic
    for (int i = 0; i < 3000; i++) begin
      logic [NP-1:0] a, b, c;
      seed = nxt(seed); a = seed[NP-1:0];
      seed = nxt(seed); a = a & seed[NP-1:0];
      seed = nxt(seed); a = a & seed[NP-1:0];
      seed = nxt(seed); b = seed[NP-1:0] & a;
      seed = nxt(seed); c = seed[NP-1:0];
      seed = nxt(seed); c = c & seed[NP-1:0] & seed[31:8];
      step(a, b ^ a, c & ~a);
    end

    // dense random traffic (R6 / R8 overlaps)
    for (int i = 0; i < 3000; i++) begin
      logic [NP-1:0] a, b, c;
      seed = nxt(seed); a = seed[NP-1:0];
      seed = nxt(seed); b = seed[NP-1:0];
      seed = nxt(seed); c = seed[NP-1:0] & seed[31:8];
      step(a, b, c);
    end

    idle(40);
    // R5 after drain: nothing left pending, no grant
    chk(gnt_vld == 1'b0, "R5 idle after drain", int'(gnt_vld), 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule